// File: doc/BRIEF.md
# GPIO Port Data-Path Register Block

This block is the register side of a 32-channel general-purpose I/O port. A simple 32-bit bus reaches a handful of word registers. They hold each channel's output level and its direction, and they return the level of the input pins. Toward the pads the block drives an output-value vector and an output-enable vector. It takes in the raw pin levels and passes them through a flop synchroniser before software can read them. Pad drivers, pull resistors, interrupts and filtering belong to other blocks.

Software can change output bits in three ways. It can write the whole output word. It can write a mask to a set alias, which raises only the masked bits. It can write a mask to a clear alias, which lowers only the masked bits. The two aliases let separate agents change disjoint bits without a read-modify-write race. To toggle bits or apply a masked value, software reads the output word and writes it back. Two read-only words report an identification value and the channel count.

The bus uses byte addresses and decodes each register only at its exact, word-aligned offset. Any other address, including one with non-zero bits above the low byte, is unmapped. Every access cycle (`bus_sel` high) is acknowledged by `bus_ready` on the following cycle. Read data is valid only in that acknowledge cycle.

Top module: `gpio_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, so every channel starts as an input. `bus_ready` is low, and the output word (0x24) and the direction word (0x28) both read back as zero.
- R2: `bus_ready` is high in the cycle after each cycle with `bus_sel` high, and low otherwise. `bus_rdata` is zero except in the acknowledge cycle of a read.
- R3: A write to offset 0x24 replaces the whole output word, and `pin_out` shows the new value from the cycle after the write.
- R4: A write to offset 0x28 sets the direction word. A 1 bit makes that channel an output, and `pin_oe` follows the word from the cycle after the write.
- R5: A write to offset 0x30 (the set alias) raises every output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R6: A write to offset 0x2C (the clear alias) lowers every output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R7: Offset 0x20 returns the pin levels through a two-flop synchroniser. A read whose access cycle starts two or more cycles after a change on `pin_in` returns the new level. A read starting in the same cycle as the change, or the cycle after it, returns the previous level.
- R8: Offsets 0x24 and 0x28 read back the current output word and direction word.
- R9: Offset 0x00 returns the parameter `ID_WORD` (default 0x67100200) and offset 0x10 returns the channel count (32 by default). These words and offset 0x20 ignore writes.
- R10: The set and clear aliases read as zero.
- R11: A write to an unmapped address changes neither `pin_out` nor `pin_oe`, and a read from one returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access cycle valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle acknowledge |
| pin_in | input | NCH (32) | Raw input pin levels |
| pin_out | output | NCH (32) | Output values toward the pads |
| pin_oe | output | NCH (32) | Output enables toward the pads |

## Verification
The hardest situation to reach is the synchroniser's edge timing. The bench has to show that a read started one cycle too early still returns the old pin level, and that a read one cycle later returns the new one. It changes `pin_in` on a falling edge and issues reads at offsets of zero, one and two cycles from that change. Alias writes with masks that partly overlap the current output word show that untouched bits survive. Writes to unaligned addresses and to addresses with upper bits set show that the decoder needs an exact match.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam logic [7:0] OFF_IDENT = 8'h00;
    localparam logic [7:0] OFF_HWCFG = 8'h10;
    localparam logic [7:0] OFF_LEVEL = 8'h20;
    localparam logic [7:0] OFF_OUTW  = 8'h24;
    localparam logic [7:0] OFF_DIRW  = 8'h28;
    localparam logic [7:0] OFF_LOWER = 8'h2C;
    localparam logic [7:0] OFF_RAISE = 8'h30;

    typedef enum logic [2:0] {
        RS_IDENT,
        RS_HWCFG,
        RS_LEVEL,
        RS_OUTW,
        RS_DIRW,
        RS_LOWER,
        RS_RAISE,
        RS_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        case (addr)
            ADDR_W'(OFF_IDENT): sel = RS_IDENT;
            ADDR_W'(OFF_HWCFG): sel = RS_HWCFG;
            ADDR_W'(OFF_LEVEL): sel = RS_LEVEL;
            ADDR_W'(OFF_OUTW):  sel = RS_OUTW;
            ADDR_W'(OFF_DIRW):  sel = RS_DIRW;
            ADDR_W'(OFF_LOWER): sel = RS_LOWER;
            ADDR_W'(OFF_RAISE): sel = RS_RAISE;
            default:            sel = RS_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NCH    = 32,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] synced
);

    logic [NCH-1:0] stg_d [STAGES];
    logic [NCH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = raw;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign synced = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_outregs.sv
module gpio_outregs
    import gpio_port_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  reg_sel_e       sel,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] dout,
    output logic [NCH-1:0] dir
);

    typedef struct packed {
        logic [NCH-1:0] dout;
        logic [NCH-1:0] dir;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                RS_OUTW:  st_d.dout = wdata;
                RS_DIRW:  st_d.dir  = wdata;
                RS_RAISE: st_d.dout = st_q.dout | wdata;
                RS_LOWER: st_d.dout = st_q.dout & ~wdata;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign dir  = st_q.dir;

    // R5: masked bits end high, the rest keep their value
    a_r5_raise_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_RAISE) |=>
            ((dout & $past(wdata)) == $past(wdata)) &&
            ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));

    // R6: masked bits end low, the rest keep their value
    a_r6_lower_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RS_LOWER) |=>
            ((dout & $past(wdata)) == '0) &&
            ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));

    // R11 and R9: writes that do not hit a writable word leave both words alone
    a_r11_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == RS_NONE || sel == RS_IDENT || sel == RS_HWCFG || sel == RS_LEVEL))
            |=> ($stable(dout) && $stable(dir)));

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int          NCH     = 32,
    parameter logic [31:0] ID_WORD = 32'h6710_0200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc,
    input  logic           wr,
    input  reg_sel_e       sel,
    input  logic [NCH-1:0] level,
    input  logic [NCH-1:0] dout,
    input  logic [NCH-1:0] dir,
    output logic [31:0]    rdata,
    output logic           ready
);

    localparam logic [31:0] CFG_WORD = 32'(NCH);

    typedef struct packed {
        logic [31:0] rdata;
        logic        ready;
    } state_t;

    state_t      st_d, st_q;
    logic [31:0] mux;

    always_comb begin
        mux = '0;
        case (sel)
            RS_IDENT: mux = ID_WORD;
            RS_HWCFG: mux = CFG_WORD;
            RS_LEVEL: mux[NCH-1:0] = level;
            RS_OUTW:  mux[NCH-1:0] = dout;
            RS_DIRW:  mux[NCH-1:0] = dir;
            default:  mux = '0;
        endcase
    end

    always_comb begin
        st_d.ready = acc;
        st_d.rdata = (acc && !wr) ? mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign ready = st_q.ready;

    // R2: one acknowledge per access cycle, one cycle later
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ready);
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !ready);

    // R10 and R11: aliases and unmapped addresses read as zero
    a_r10_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr && (sel == RS_RAISE || sel == RS_LOWER || sel == RS_NONE))
            |=> (rdata == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int          NCH     = 32,
    parameter int          ADDR_W  = 12,
    parameter int          SYNC_N  = 2,
    parameter logic [31:0] ID_WORD = 32'h6710_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    input  logic [NCH-1:0]    pin_in,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe
);

    reg_sel_e       sel;
    logic [NCH-1:0] level;
    logic [NCH-1:0] dout;
    logic [NCH-1:0] dir;

    gpio_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_sync #(.NCH(NCH), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (level)
    );

    gpio_outregs #(.NCH(NCH)) u_outregs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_sel && bus_wr),
        .sel   (sel),
        .wdata (bus_wdata[NCH-1:0]),
        .dout  (dout),
        .dir   (dir)
    );

    gpio_readback #(.NCH(NCH), .ID_WORD(ID_WORD)) u_readback (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (bus_sel),
        .wr    (bus_wr),
        .sel   (sel),
        .level (level),
        .dout  (dout),
        .dir   (dir),
        .rdata (bus_rdata),
        .ready (bus_ready)
    );

    assign pin_out = dout;
    assign pin_oe  = dir;

    // R3: a full write lands on the pads one cycle later
    a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && sel == RS_OUTW) |=> (pin_out == $past(bus_wdata[NCH-1:0])));

    // R4: direction write lands on the enables one cycle later
    a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && sel == RS_DIRW) |=> (pin_oe == $past(bus_wdata[NCH-1:0])));

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    typedef struct {
        logic        is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one access cycle, expected result pushed to the scoreboard
    task automatic access(logic wr, logic [11:0] addr, logic [31:0] wd,
                          logic [31:0] exp, string tag);
        item_t it;
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = wd;
        it.is_rd  = !wr;
        it.exp    = wr ? 32'h0 : exp;
        it.tag    = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        access(1'b1, a, d, 32'h0, tag);
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        access(1'b0, a, 32'h0, e, tag);
    endtask

    // monitor: each acknowledge pops one expected item
    always @(negedge clk) begin
        if (rst_n && bus_ready) begin
            if (sb_q.size() == 0) begin
                chk("R2 unexpected ready", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pin_out reset", pin_out, 32'h0);
        chk("R1 pin_oe reset", pin_oe, 32'h0);
        chk("R1 ready reset", {31'h0, bus_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h024, 32'h0, "R1 out word after reset");
        rd(12'h028, 32'h0, "R1 dir word after reset");
        @(negedge clk);
        chk("R2 ready drops when idle", {31'h0, bus_ready}, 32'h0);

        rd(12'h000, 32'h6710_0200, "R9 ident word");
        rd(12'h010, 32'd32, "R9 config word");
        wr(12'h000, 32'hFFFF_FFFF, "R2 write rdata zero");
        wr(12'h010, 32'h0, "R2 write rdata zero");
        rd(12'h000, 32'h6710_0200, "R9 ident after write");
        rd(12'h010, 32'd32, "R9 config after write");

        wr(12'h028, 32'hFFFF_0000, "R2 write rdata zero");
        chk("R4 pin_oe after dir write", pin_oe, 32'hFFFF_0000);
        rd(12'h028, 32'hFFFF_0000, "R8 dir readback");

        wr(12'h024, 32'hA5A5_5A5A, "R2 write rdata zero");
        chk("R3 pin_out after full write", pin_out, 32'hA5A5_5A5A);
        rd(12'h024, 32'hA5A5_5A5A, "R8 out readback");

        wr(12'h030, 32'h0000_00F0, "R2 write rdata zero");
        chk("R5 raise partial mask", pin_out, 32'hA5A5_5AFA);
        rd(12'h030, 32'h0, "R10 raise alias reads zero");
        wr(12'h02C, 32'hA000_0002, "R2 write rdata zero");
        chk("R6 lower partial mask", pin_out, 32'h05A5_5AF8);
        rd(12'h02C, 32'h0, "R10 lower alias reads zero");
        wr(12'h030, 32'h0, "R2 write rdata zero");
        chk("R5 empty mask keeps word", pin_out, 32'h05A5_5AF8);
        wr(12'h030, 32'hFFFF_FFFF, "R2 write rdata zero");
        chk("R5 full mask raises all", pin_out, 32'hFFFF_FFFF);
        wr(12'h02C, 32'h0F0F_0F0F, "R2 write rdata zero");
        chk("R6 lower pattern", pin_out, 32'hF0F0_F0F0);
        rd(12'h024, 32'hF0F0_F0F0, "R8 out after aliases");
        chk("R6 alias leaves dir", pin_oe, 32'hFFFF_0000);

        wr(12'h014, 32'h1234_5678, "R2 write rdata zero");
        wr(12'h025, 32'h1234_5678, "R2 write rdata zero");
        wr(12'h124, 32'h1234_5678, "R2 write rdata zero");
        wr(12'h128, 32'h1234_5678, "R2 write rdata zero");
        wr(12'h020, 32'h1234_5678, "R2 write rdata zero");
        chk("R11 unmapped writes keep pin_out", pin_out, 32'hF0F0_F0F0);
        chk("R11 unmapped writes keep pin_oe", pin_oe, 32'hFFFF_0000);
        rd(12'h014, 32'h0, "R11 unmapped read 0x014");
        rd(12'h124, 32'h0, "R11 upper-bit alias read");
        rd(12'h026, 32'h0, "R11 unaligned read");

        pin_in = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        rd(12'h020, 32'hDEAD_BEEF, "R7 level after two cycles");
        pin_in = 32'h1357_9BDF;
        rd(12'h020, 32'hDEAD_BEEF, "R7 same-cycle read old level");
        rd(12'h020, 32'hDEAD_BEEF, "R7 next-cycle read old level");
        rd(12'h020, 32'h1357_9BDF, "R7 two-cycle read new level");
        rd(12'h020, 32'h1357_9BDF, "R9 level unaffected by write");

        wr(12'h024, 32'h0000_0001, "R2 write rdata zero");
        wr(12'h028, 32'h0000_0000, "R2 write rdata zero");
        chk("R3 second full write", pin_out, 32'h0000_0001);
        chk("R4 all inputs again", pin_oe, 32'h0);

        @(negedge clk);
        @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb_q.size()), 32'h0);
        finish_run();
    end

endmodule